// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block drives the state changes a processor core needs to enter an exception handler and to leave it again. Seven request lines can be raised: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. The block reads the core's current status word and program counter. When it accepts a request, it emits one cycle in which three things happen together. It writes a new status word with the target mode and the updated interrupt masks. It writes the return address into the target mode's link slot of an external banked register file. It forces the program counter to a fixed per-exception vector. In the same cycle it keeps a private copy of the old status word in the saved-status slot of the target mode.

A return command undoes an entry. The status word comes back from the saved-status slot of the current mode, and the program counter is loaded with the link value read from the banked register file. The block points that file's read port at the current mode's bank. A return issued from the unprivileged user mode performs no load and only flags an error.

The status word itself lives outside the block. The core is expected to load it from the new-status output whenever the status strobe is high, and to load the program counter when the PC strobe is high.

Top module: `exc_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pc_load_o`, `st_load_o`, `rf_we_o` and `err_o` are 0.
- R2: One clock after a non-reset request is accepted, `rf_we_o` is 1, `rf_data_o` is the sampled `pc_i` plus 4, and `rf_bank_o` is the bank of the target mode. Banks are: fast interrupt 0, interrupt 1, supervisor 2, abort 3, undefined 4. In the same edge, the sampled status word is stored in that bank's saved-status slot.
- R3: On entry, `st_new_o` equals the sampled status word with bits [4:0] replaced by the target mode code. Mode codes are: user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B. Reset and software interrupt target supervisor. Prefetch abort and data abort target abort. Undefined targets undefined. Interrupts target their own modes.
- R4: Every entry sets status bit 7 (interrupt mask). Fast interrupt and reset entries also set bit 6 (fast interrupt mask). Otherwise bit 6 is copied unchanged.
- R5: On entry, `pc_load_o` pulses and `pc_new_o` carries the vector: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C.
- R6: `req_i` bits are reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, interrupt 5, fast interrupt 6. If several eligible requests are raised together, the winner is chosen in this order, highest first: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt.
- R7: An interrupt request is eligible only while status bit 7 is 0. A fast interrupt request is eligible only while status bit 6 is 0.
- R8: A return command in any mode other than user loads `st_new_o` from the current mode's saved-status slot and `pc_new_o` from `lr_data_i`, one clock later. It pulses both strobes and does not write the register file.
- R9: A return command in user mode (0x10) causes no load of any kind and pulses `err_o` for one cycle, one clock later.
- R10: Reset entry targets supervisor with bits 7 and 6 set. It writes neither the saved-status slot nor the register file.
- R11: In the cycle after a load pulse, requests and return commands are ignored. If an eligible request and a return command arrive together, the request wins and the return is dropped.
- R12: `lr_bank_o` combinationally gives the bank of the mode in `status_i[4:0]`, using the numbering of R2. User mode and any unknown mode code map to bank 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 7 | Exception request lines, bit layout as in R6 |
| status_i | input | SW | Current status word |
| pc_i | input | AW | Current program counter |
| ret_i | input | 1 | Return-from-handler command |
| lr_data_i | input | AW | Link value read from the bank named by `lr_bank_o` |
| lr_bank_o | output | 3 | Read bank for the link register file |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_new_o | output | AW | New program counter value |
| st_load_o | output | 1 | Status word load strobe |
| st_new_o | output | SW | New status word |
| rf_we_o | output | 1 | Link register write strobe |
| rf_bank_o | output | 3 | Link register bank to write |
| rf_data_o | output | AW | Return address to write |
| err_o | output | 1 | Return attempted from user mode |

## Verification
The assertions take for granted that `status_i` is the register the core reloads from `st_new_o` on every status strobe, so that the mask bits seen at acceptance belong to the status word that governed it. They also assume `pc_i` is word aligned. The bench meets both assumptions. It keeps its own status register, which starts in user mode with both masks clear and changes only on the block's status strobe. It keeps its own banked link file, which changes only on `rf_we_o`. Program counters are always drawn as multiples of four. Nested entries and returns then arise naturally from random requests and return commands.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EX_RST  = 3'd0,
        EX_UND  = 3'd1,
        EX_SWI  = 3'd2,
        EX_PABT = 3'd3,
        EX_DABT = 3'd4,
        EX_IRQ  = 3'd5,
        EX_FIQ  = 3'd6
    } exc_e;

    localparam int NEXC   = 7;
    localparam int NBANK  = 5;
    localparam int BANK_W = $clog2(NBANK);
    localparam int IBIT   = 7;
    localparam int FBIT   = 6;

    localparam logic [4:0] M_USR = 5'h10;
    localparam logic [4:0] M_FIQ = 5'h11;
    localparam logic [4:0] M_IRQ = 5'h12;
    localparam logic [4:0] M_SVC = 5'h13;
    localparam logic [4:0] M_ABT = 5'h17;
    localparam logic [4:0] M_UND = 5'h1B;

    // target mode of each exception kind
    function automatic logic [4:0] exc_mode(exc_e e);
        case (e)
            EX_UND:           return M_UND;
            EX_PABT, EX_DABT: return M_ABT;
            EX_IRQ:           return M_IRQ;
            EX_FIQ:           return M_FIQ;
            default:          return M_SVC;
        endcase
    endfunction

    // banked slot index of a mode; unbanked or unknown modes fall on supervisor
    function automatic logic [BANK_W-1:0] mode_bank(logic [4:0] m);
        case (m)
            M_FIQ:   return BANK_W'(0);
            M_IRQ:   return BANK_W'(1);
            M_ABT:   return BANK_W'(3);
            M_UND:   return BANK_W'(4);
            default: return BANK_W'(2);
        endcase
    endfunction

    // word vectors: kinds 0..4 on consecutive words, slot 0x14 skipped
    function automatic logic [7:0] exc_vector(exc_e e);
        logic [7:0] k;
        k = {5'd0, e};
        if (e == EX_IRQ || e == EX_FIQ) k = k + 8'd1;
        return {k[5:0], 2'b00};
    endfunction

    // priority rank -> exception kind, rank 0 highest
    function automatic exc_e prio_at(int rank);
        case (rank)
            0:       return EX_RST;
            1:       return EX_DABT;
            2:       return EX_FIQ;
            3:       return EX_IRQ;
            4:       return EX_PABT;
            5:       return EX_UND;
            default: return EX_SWI;
        endcase
    endfunction

endpackage

// File: rtl/exc_arb.sv
module exc_arb
    import exc_pkg::*;
(
    input  logic [NEXC-1:0] req_i,
    input  logic            irq_off_i,
    input  logic            fiq_off_i,
    output logic            hit_o,
    output exc_e            sel_o
);

    logic [NEXC-1:0] live;

    always_comb begin
        live          = req_i;
        live[EX_IRQ]  = req_i[EX_IRQ] & ~irq_off_i;
        live[EX_FIQ]  = req_i[EX_FIQ] & ~fiq_off_i;
        hit_o         = |live;
        sel_o         = EX_SWI;
        // walk from lowest to highest rank so the highest live one remains
        for (int r = NEXC - 1; r >= 0; r--) begin
            if (live[prio_at(r)]) sel_o = prio_at(r);
        end
    end

endmodule

// File: rtl/exc_sbank.sv
module exc_sbank #(
    parameter int SW = 32,
    parameter int NB = 5,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  logic [SW-1:0] wdata_i,
    input  logic [IW-1:0] ridx_i,
    output logic [SW-1:0] rdata_o
);

    logic [SW-1:0] slot_w [NB];

    for (genvar g = 0; g < NB; g++) begin : g_slot
        logic [SW-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (we_i && widx_i == IW'(g)) val_d = wdata_i;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign slot_w[g] = val_q;
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NB; i++) begin
            if (ridx_i == IW'(i)) rdata_o = slot_w[i];
        end
    end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SW      = 32,
    parameter int RET_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NEXC-1:0]   req_i,
    input  logic [SW-1:0]     status_i,
    input  logic [AW-1:0]     pc_i,
    input  logic              ret_i,
    input  logic [AW-1:0]     lr_data_i,
    output logic [BANK_W-1:0] lr_bank_o,
    output logic              pc_load_o,
    output logic [AW-1:0]     pc_new_o,
    output logic              st_load_o,
    output logic [SW-1:0]     st_new_o,
    output logic              rf_we_o,
    output logic [BANK_W-1:0] rf_bank_o,
    output logic [AW-1:0]     rf_data_o,
    output logic              err_o
);

    typedef struct packed {
        logic              pc_load;
        logic [AW-1:0]     pc_new;
        logic              st_load;
        logic [SW-1:0]     st_new;
        logic              rf_we;
        logic [BANK_W-1:0] rf_bank;
        logic [AW-1:0]     rf_data;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              hit;
    exc_e              sel;
    logic [4:0]        cur_mode;
    logic [BANK_W-1:0] cur_bank;
    logic              sv_we;
    logic [BANK_W-1:0] sv_widx;
    logic [SW-1:0]     sv_rdata;
    logic [4:0]        tgt_mode;
    logic [SW-1:0]     entry_st;

    assign cur_mode  = status_i[4:0];
    assign cur_bank  = mode_bank(cur_mode);
    assign lr_bank_o = cur_bank;

    exc_arb u_arb (
        .req_i     (req_i),
        .irq_off_i (status_i[IBIT]),
        .fiq_off_i (status_i[FBIT]),
        .hit_o     (hit),
        .sel_o     (sel)
    );

    exc_sbank #(.SW(SW), .NB(NBANK)) u_sbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (sv_we),
        .widx_i  (sv_widx),
        .wdata_i (status_i),
        .ridx_i  (cur_bank),
        .rdata_o (sv_rdata)
    );

    always_comb begin
        tgt_mode       = exc_mode(sel);
        entry_st       = status_i;
        entry_st[4:0]  = tgt_mode;
        entry_st[IBIT] = 1'b1;
        if (sel == EX_FIQ || sel == EX_RST) entry_st[FBIT] = 1'b1;

        seq_d   = '0;
        sv_we   = 1'b0;
        sv_widx = mode_bank(tgt_mode);

        // one quiet cycle after every load so the new status is seen first
        if (!seq_q.pc_load) begin
            if (hit) begin
                seq_d.pc_load = 1'b1;
                seq_d.pc_new  = {{(AW-8){1'b0}}, exc_vector(sel)};
                seq_d.st_load = 1'b1;
                seq_d.st_new  = entry_st;
                if (sel != EX_RST) begin
                    seq_d.rf_we   = 1'b1;
                    seq_d.rf_bank = mode_bank(tgt_mode);
                    seq_d.rf_data = pc_i + AW'(RET_OFS);
                    sv_we         = 1'b1;
                end
            end else if (ret_i) begin
                if (cur_mode == M_USR) begin
                    seq_d.err = 1'b1;
                end else begin
                    seq_d.pc_load = 1'b1;
                    seq_d.pc_new  = lr_data_i;
                    seq_d.st_load = 1'b1;
                    seq_d.st_new  = sv_rdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign pc_load_o = seq_q.pc_load;
    assign pc_new_o  = seq_q.pc_new;
    assign st_load_o = seq_q.st_load;
    assign st_new_o  = seq_q.st_new;
    assign rf_we_o   = seq_q.rf_we;
    assign rf_bank_o = seq_q.rf_bank;
    assign rf_data_o = seq_q.rf_data;
    assign err_o     = seq_q.err;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
    import exc_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SW-1:0]     status_i,
    input logic              pc_load_o,
    input logic [AW-1:0]     pc_new_o,
    input logic              st_load_o,
    input logic [SW-1:0]     st_new_o,
    input logic              rf_we_o,
    input logic [BANK_W-1:0] rf_bank_o,
    input logic              err_o
);

    p_entry_atomic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (pc_load_o && st_load_o));

    p_bank_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (rf_bank_o == mode_bank(st_new_o[4:0])));

    p_irq_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> st_new_o[IBIT]);

    p_fiq_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && st_new_o[4:0] == M_FIQ) |-> st_new_o[FBIT]);

    p_vector_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (pc_new_o <= AW'(32'h1C) && pc_new_o[1:0] == 2'b00
                     && pc_new_o != AW'(32'h14)));

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && st_new_o[4:0] == M_IRQ) |-> !$past(status_i[IBIT]));

    p_user_ret_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !(pc_load_o || st_load_o || rf_we_o));

    p_load_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !pc_load_o);

endmodule

bind exc_seq exc_seq_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_i  (status_i),
    .pc_load_o (pc_load_o),
    .pc_new_o  (pc_new_o),
    .st_load_o (st_load_o),
    .st_new_o  (st_new_o),
    .rf_we_o   (rf_we_o),
    .rf_bank_o (rf_bank_o),
    .err_o     (err_o)
);

// File: tb/test_exc_seq.sv
module test_exc_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  req = '0;
    logic [31:0] sts = 32'h10;
    logic [31:0] pc = '0;
    logic        ret = 1'b0;
    logic [31:0] lrf [5];
    logic [31:0] lr_data;

    logic [2:0]  lr_bank_o, rf_bank_o;
    logic        pc_load_o, st_load_o, rf_we_o, err_o;
    logic [31:0] pc_new_o, st_new_o, rf_data_o;

    always #5 clk = ~clk;

    exc_seq i_exc_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .status_i  (sts),
        .pc_i      (pc),
        .ret_i     (ret),
        .lr_data_i (lr_data),
        .lr_bank_o (lr_bank_o),
        .pc_load_o (pc_load_o),
        .pc_new_o  (pc_new_o),
        .st_load_o (st_load_o),
        .st_new_o  (st_new_o),
        .rf_we_o   (rf_we_o),
        .rf_bank_o (rf_bank_o),
        .rf_data_o (rf_data_o),
        .err_o     (err_o)
    );

    int checks = 0;
    int errors = 0;

    // reference state
    logic        e_pl = 0, e_sl = 0, e_we = 0, e_err = 0;
    logic [31:0] e_pc = 0, e_st = 0, e_rd = 0;
    logic [2:0]  e_bank = 0;
    logic [31:0] msave [5];
    int          prio [7] = '{0, 4, 6, 5, 3, 1, 2};

    function automatic logic [2:0] bnk(logic [4:0] m);
        case (m)
            5'h11:   return 3'd0;
            5'h12:   return 3'd1;
            5'h17:   return 3'd3;
            5'h1B:   return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

    assign lr_data = lrf[bnk(sts[4:0])];

    function automatic logic [31:0] vec(int k);
        case (k)
            0: return 32'h00;  1: return 32'h04;  2: return 32'h08;
            3: return 32'h0C;  4: return 32'h10;  5: return 32'h18;
            default: return 32'h1C;
        endcase
    endfunction

    function automatic logic [4:0] tmode(int k);
        case (k)
            1:       return 5'h1B;
            3, 4:    return 5'h17;
            5:       return 5'h12;
            6:       return 5'h11;
            default: return 5'h13;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk("R5 pc_load", 32'(pc_load_o), 32'(e_pl));
        chk("R5 pc_new", pc_new_o, e_pc);
        chk("R3 st_load", 32'(st_load_o), 32'(e_sl));
        chk("R3 st_new mode", 32'(st_new_o[4:0]), 32'(e_st[4:0]));
        chk("R4 st_new masks", 32'(st_new_o[7:6]), 32'(e_st[7:6]));
        chk("R3 st_new rest", {st_new_o[31:8], st_new_o[5], 7'd0}, {e_st[31:8], e_st[5], 7'd0});
        chk("R2 rf_we", 32'(rf_we_o), 32'(e_we));
        chk("R2 rf_bank", 32'(rf_bank_o), 32'(e_bank));
        chk("R2 rf_data", rf_data_o, e_rd);
        chk("R9 err", 32'(err_o), 32'(e_err));
        chk("R12 lr_bank", 32'(lr_bank_o), 32'(bnk(sts[4:0])));
    endtask

    task automatic model();
        logic        npl = 0, nsl = 0, nwe = 0, nerr = 0;
        logic [31:0] npc = 0, nst = 0, nrd = 0;
        logic [2:0]  nbank = 0;
        int          win = -1;
        if (!e_pl) begin
            for (int i = 6; i >= 0; i--) begin
                int  b = prio[i];
                bit  ok = req[b];
                if (b == 5 && sts[7]) ok = 0;
                if (b == 6 && sts[6]) ok = 0;
                if (ok) win = b;
            end
            if (win >= 0) begin
                nst = sts;
                nst[4:0] = tmode(win);
                nst[7] = 1'b1;
                if (win == 6 || win == 0) nst[6] = 1'b1;
                npl = 1; nsl = 1;
                npc = vec(win);
                if (win != 0) begin
                    nwe = 1;
                    nbank = bnk(tmode(win));
                    nrd = pc + 32'd4;
                    msave[nbank] = sts;
                end
            end else if (ret) begin
                if (sts[4:0] == 5'h10) nerr = 1;
                else begin
                    npl = 1; nsl = 1;
                    npc = lrf[bnk(sts[4:0])];
                    nst = msave[bnk(sts[4:0])];
                end
            end
        end
        e_pl = npl; e_pc = npc; e_sl = nsl; e_st = nst;
        e_we = nwe; e_bank = nbank; e_rd = nrd; e_err = nerr;
    endtask

    // called at a falling edge; returns at the falling edge after the next rise
    task automatic cyc(logic [6:0] r, logic rt, logic [31:0] p);
        compare();
        if (e_sl) sts = e_st;
        if (e_we) lrf[e_bank] = e_rd;
        req = r; ret = rt; pc = p;
        model();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 5; i++) begin
            lrf[i] = '0;
            msave[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc_load in reset", 32'(pc_load_o), 0);
        chk("R1 st_load in reset", 32'(st_load_o), 0);
        chk("R1 rf_we in reset", 32'(rf_we_o), 0);
        chk("R1 err in reset", 32'(err_o), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 pc_load after reset", 32'(pc_load_o), 0);

        cyc(7'b0000000, 1, 32'h200);
        chk("R9 err on user return", 32'(err_o), 1);
        chk("R9 no load on user return", 32'(pc_load_o), 0);

        cyc(7'b0000100, 0, 32'h100);
        chk("R5 swi vector", pc_new_o, 32'h08);
        chk("R3 swi status", st_new_o, 32'h93);
        chk("R2 swi link", rf_data_o, 32'h104);
        chk("R2 swi bank", 32'(rf_bank_o), 2);

        cyc(7'b0100000, 0, 0);
        chk("R11 quiet after load", 32'(pc_load_o), 0);
        cyc(7'b0100000, 0, 0);
        chk("R7 irq masked", 32'(pc_load_o), 0);
        cyc(7'b0100000, 1, 0);
        chk("R8 return status", st_new_o, 32'h10);
        chk("R8 return pc", pc_new_o, 32'h104);
        chk("R8 return no rf write", 32'(rf_we_o), 0);
        cyc(0, 0, 0);

        cyc(7'h7F, 0, 32'h300);
        chk("R6 reset wins", pc_new_o, 32'h00);
        chk("R10 reset status", st_new_o, 32'hD3);
        chk("R10 reset no rf write", 32'(rf_we_o), 0);
        cyc(0, 0, 0);
        cyc(0, 1, 0);
        chk("R10 saved slot kept", st_new_o, 32'h10);
        chk("R10 link kept", pc_new_o, 32'h104);
        cyc(0, 0, 0);

        cyc(7'h7E, 0, 32'h400);
        chk("R6 dabt wins", pc_new_o, 32'h10);
        chk("R3 abort status", st_new_o, 32'h97);
        cyc(0, 0, 0); cyc(0, 1, 0); cyc(0, 0, 0);

        cyc(7'b1101110, 0, 32'h500);
        chk("R4 fiq vector", pc_new_o, 32'h1C);
        chk("R4 fiq status", st_new_o, 32'hD1);
        cyc(0, 0, 0);
        chk("R12 fiq bank read", 32'(lr_bank_o), 0);
        cyc(0, 1, 0); cyc(0, 0, 0);

        cyc(7'b0101010, 0, 32'h600);
        chk("R6 irq over pabt", pc_new_o, 32'h18);
        chk("R4 irq status", st_new_o, 32'h92);
        cyc(0, 0, 0); cyc(0, 1, 0); cyc(0, 0, 0);

        cyc(7'b0001010, 0, 32'h700);
        chk("R6 pabt over und", pc_new_o, 32'h0C);
        cyc(0, 0, 0); cyc(0, 1, 0); cyc(0, 0, 0);

        cyc(7'b0000010, 1, 32'h800);
        chk("R11 entry beats return", pc_new_o, 32'h04);
        chk("R11 entry writes link", 32'(rf_we_o), 1);
        cyc(0, 0, 0); cyc(0, 1, 0); cyc(0, 0, 0);

        for (int n = 0; n < 4000; n++) begin
            logic [6:0] r = '0;
            int sel = $urandom % 8;
            if (sel != 0 && ($urandom % 6) == 0) r[sel - 1] = 1'b1;
            if (r[0] && ($urandom % 8) != 0) r = '0;
            if (($urandom % 10) == 0) r[5] = 1'b1;
            cyc(r, ($urandom % 4) == 0, $urandom & 32'hFFFF_FFFC);
        end
        cyc(0, 0, 0);
        compare();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule